// File: doc/BRIEF.md
# Destination-Tag Multistage Switch Network

This block connects N sources to N destinations through log2 N columns of 2x2 crossbar switches. Each switch stores nothing. Every source presents a valid flag, a destination index and a data word. Each column steers a message with one bit of its destination index, starting from the most significant bit. A perfect-shuffle wiring pattern (rotate the line index left by one) sits in front of every column, so any source can reach any destination. Each column ends in one register stage, so a message crosses the network in exactly log2 N cycles. A new set of messages can enter on every cycle.

Two messages can want the same output of one switch in the same cycle. The message on the upper input then wins, and the other is discarded. The source of the discarded message sees a one-cycle blocked flag. This flag arrives in the same cycle its message would have reached the far side, so the source can pair the flag with the cycle it sent in and send again.

Top module: `omn_network`

## Requirements
- R1: After reset, with no message sent, every `out_valid`, `out_data` and `src_blocked` bit is zero.
- R2: A message that is not discarded appears at its output exactly AW = log2 N clock edges after it is sampled, with its data word unchanged.
- R3: The output index equals the destination field of the source (`in_dest[s*AW +: AW]`), for every source and destination pair.
- R4: A message that is alone in its wave is never discarded.
- R5: Column i steers on destination bit AW-1-i, with 0 choosing the upper switch output and 1 the lower. When both inputs of a switch choose the same output, the upper input wins. The lower message is dropped, and `src_blocked[s]` for its source s is high for exactly one cycle, AW edges after the message was sampled.
- R6: Every valid input is either delivered or reported blocked, never both, and no output carries a message that was not sent.
- R7: A source whose `in_valid` bit is low contributes nothing, whatever its destination and data. An output with no message drives zero data.
- R8: The network accepts a full wave on every cycle. A cyclic-shift permutation (source s to destination (s+k) mod N) passes with no source blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N | One message request per source |
| in_dest | input | N*AW | Destination index per source, source s at bits s*AW +: AW |
| in_data | input | N*DW | Data word per source, source s at bits s*DW +: DW |
| out_valid | output | N | A message is present at this output |
| out_data | output | N*DW | Data word per output, zero when no message |
| src_blocked | output | N | Source's message of AW cycles earlier was dropped |

## Verification
The bench builds the network with N = 8 and DW = 8, which gives three switch columns of four switches each. At this size a wave can lose messages at the first, middle or last column. Random waves of mixed density therefore drive collisions at every depth, and the bench compares each of them against an independent path model on every cycle. A full sweep of all 64 single-message pairs runs alongside these, together with a forced first-column collision and back-to-back shift permutations.

// File: rtl/omn_pkg.sv
package omn_pkg;

    // Which switch output a message selects from its routing bit.
    typedef enum logic {
        PORT_UP = 1'b0,
        PORT_DN = 1'b1
    } omn_port_e;

    // Inverse of the perfect shuffle: the line that feeds shuffled line p.
    function automatic int unsigned omn_unshuffle(int unsigned p, int unsigned w);
        int unsigned mask;
        mask = (32'd1 << w) - 32'd1;
        return ((p >> 1) | ((p & 32'd1) << (w - 32'd1))) & mask;
    endfunction

endpackage

// File: rtl/omn_switch.sv
module omn_switch #(
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int BIT = 2,
    localparam int LW = 1 + 2 * AW + DW
) (
    input  logic [LW-1:0] up_i,
    input  logic [LW-1:0] dn_i,
    output logic [LW-1:0] up_o,
    output logic [LW-1:0] dn_o,
    output logic          drop_o,
    output logic [AW-1:0] drop_src_o
);
    import omn_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        logic [DW-1:0] dat;
    } lane_t;

    lane_t a, b, ya, yb;
    logic  a_dn, b_dn;

    always_comb begin
        a    = lane_t'(up_i);
        b    = lane_t'(dn_i);
        a_dn = (a.dst[BIT] == PORT_DN);
        b_dn = (b.dst[BIT] == PORT_DN);
        ya   = '0;
        yb   = '0;
        // upper input has fixed priority on either output
        if (a.vld && !a_dn)      ya = a;
        else if (b.vld && !b_dn) ya = b;
        if (a.vld && a_dn)       yb = a;
        else if (b.vld && b_dn)  yb = b;
        drop_o     = a.vld && b.vld && (a_dn == b_dn);
        drop_src_o = b.src;
        up_o       = ya;
        dn_o       = yb;
    end

endmodule

// File: rtl/omn_stage.sv
module omn_stage #(
    parameter int N   = 8,
    parameter int AW  = 3,
    parameter int DW  = 8,
    parameter int STG = 0,
    localparam int LW   = 1 + 2 * AW + DW,
    localparam int HALF = N / 2,
    localparam int BIT  = AW - 1 - STG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*LW-1:0] lanes_i,
    input  logic [N-1:0]    blk_i,
    output logic [N*LW-1:0] lanes_o,
    output logic [N-1:0]    blk_o
);
    typedef struct packed {
        logic [N*LW-1:0] lanes;
        logic [N-1:0]    blk;
    } stage_t;

    stage_t st_d, st_q;

    logic [N*LW-1:0]          sw_out;
    logic [HALF-1:0]          drop;
    logic [HALF-1:0][AW-1:0]  drop_src;

    for (genvar j = 0; j < HALF; j++) begin : g_sw
        localparam int UP_SRC = int'(omn_pkg::omn_unshuffle(2 * j, AW));
        localparam int DN_SRC = int'(omn_pkg::omn_unshuffle(2 * j + 1, AW));
        omn_switch #(.AW(AW), .DW(DW), .BIT(BIT)) u_sw (
            .up_i       (lanes_i[UP_SRC*LW +: LW]),
            .dn_i       (lanes_i[DN_SRC*LW +: LW]),
            .up_o       (sw_out[(2*j)*LW +: LW]),
            .dn_o       (sw_out[(2*j+1)*LW +: LW]),
            .drop_o     (drop[j]),
            .drop_src_o (drop_src[j])
        );
    end

    always_comb begin
        st_d.lanes = sw_out;
        st_d.blk   = blk_i;
        for (int j = 0; j < HALF; j++) begin
            if (drop[j]) st_d.blk[drop_src[j]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lanes_o = st_q.lanes;
    assign blk_o   = st_q.blk;

endmodule

// File: rtl/omn_network.sv
module omn_network #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int AW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    in_valid,
    input  logic [N*AW-1:0] in_dest,
    input  logic [N*DW-1:0] in_data,
    output logic [N-1:0]    out_valid,
    output logic [N*DW-1:0] out_data,
    output logic [N-1:0]    src_blocked
);
    localparam int LW = 1 + 2 * AW + DW;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] dst;
        logic [AW-1:0] src;
        logic [DW-1:0] dat;
    } lane_t;

    logic [N*LW-1:0] lane_bus [AW+1];
    logic [N-1:0]    blk_bus  [AW+1];

    always_comb begin
        lane_t t;
        for (int s = 0; s < N; s++) begin
            t.vld = in_valid[s];
            t.dst = in_dest[s*AW +: AW];
            t.src = AW'(s);
            t.dat = in_data[s*DW +: DW];
            lane_bus[0][s*LW +: LW] = t;
        end
        blk_bus[0] = '0;
    end

    for (genvar i = 0; i < AW; i++) begin : g_stg
        omn_stage #(.N(N), .AW(AW), .DW(DW), .STG(i)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .lanes_i (lane_bus[i]),
            .blk_i   (blk_bus[i]),
            .lanes_o (lane_bus[i+1]),
            .blk_o   (blk_bus[i+1])
        );
    end

    always_comb begin
        lane_t t;
        for (int k = 0; k < N; k++) begin
            t                    = lane_t'(lane_bus[AW][k*LW +: LW]);
            out_valid[k]         = t.vld;
            out_data[k*DW +: DW] = t.vld ? t.dat : '0;
        end
        src_blocked = blk_bus[AW];
    end

endmodule

// File: rtl/omn_network_chk.sv
module omn_network_chk #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int AW = $clog2(N)
) (
    input logic            clk,
    input logic            rst,
    input logic [N-1:0]    in_valid,
    input logic [N*AW-1:0] in_dest,
    input logic [N-1:0]    out_valid,
    input logic [N-1:0]    src_blocked
);
    logic [N-1:0] vpipe [AW];
    logic [N-1:0] rpipe [AW];
    logic [N-1:0] reach_now;

    always_comb begin
        reach_now = '0;
        for (int s = 0; s < N; s++) begin
            if (in_valid[s]) reach_now[in_dest[s*AW +: AW]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < AW; i++) begin
                vpipe[i] <= '0;
                rpipe[i] <= '0;
            end
        end else begin
            vpipe[0] <= in_valid;
            rpipe[0] <= reach_now;
            for (int i = 1; i < AW; i++) begin
                vpipe[i] <= vpipe[i-1];
                rpipe[i] <= rpipe[i-1];
            end
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && src_blocked == '0));

    // R6
    conserve_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(out_valid) + $countones(src_blocked)) == $countones(vpipe[AW-1]));

    // R5
    blocked_src_chk: assert property (@(posedge clk) disable iff (rst)
        (src_blocked & ~vpipe[AW-1]) == '0);

    // R3
    reach_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid & ~rpipe[AW-1]) == '0);

    // R4
    lone_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(vpipe[AW-1]) == 1) |-> (src_blocked == '0));

endmodule

bind omn_network omn_network_chk #(.N(N), .DW(DW)) i_omn_network_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_dest     (in_dest),
    .out_valid   (out_valid),
    .src_blocked (src_blocked)
);

// File: tb/test_omn_network.sv
module test_omn_network;
    localparam int N      = 8;
    localparam int DW     = 8;
    localparam int AW     = $clog2(N);
    localparam int CLK_NS = 10;
    localparam int WD_MAX = 100000;

    typedef struct packed {
        logic [N-1:0]    v;
        logic [N-1:0]    b;
        logic [N*DW-1:0] d;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    in_valid = '0;
    logic [N*AW-1:0] in_dest = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    src_blocked;

    int   errors = 0;
    int   checks = 0;
    int   cyc    = 0;
    exp_t q[$];

    always #(CLK_NS/2) clk = ~clk;

    omn_network #(.N(N), .DW(DW)) i_omn_network (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .src_blocked(src_blocked)
    );

    function automatic int rotl(int p);
        return ((p << 1) | (p >> (AW - 1))) & (N - 1);
    endfunction

    // Path model: follows each message line by line, upper line claims first.
    function automatic exp_t model(logic [N-1:0] v, logic [N*AW-1:0] dst, logic [N*DW-1:0] dat);
        int   pos[N];
        bit   live[N];
        int   at[N];
        bit   taken[N];
        exp_t e;
        e = '0;
        for (int s = 0; s < N; s++) begin
            pos[s]  = s;
            live[s] = v[s];
        end
        for (int i = 0; i < AW; i++) begin
            for (int l = 0; l < N; l++) begin
                at[l]    = -1;
                taken[l] = 0;
            end
            for (int s = 0; s < N; s++) begin
                if (live[s]) begin
                    pos[s]     = rotl(pos[s]);
                    at[pos[s]] = s;
                end
            end
            for (int l = 0; l < N; l++) begin
                if (at[l] >= 0) begin
                    int s;
                    int np;
                    s  = at[l];
                    np = (l & ~1) | int'(dst[s*AW + AW - 1 - i]);
                    if (taken[np]) begin
                        live[s] = 0;
                        e.b[s]  = 1'b1;
                    end else begin
                        taken[np] = 1;
                        pos[s]    = np;
                    end
                end
            end
        end
        for (int s = 0; s < N; s++) begin
            if (live[s]) begin
                e.v[pos[s]]           = 1'b1;
                e.d[pos[s]*DW +: DW]  = dat[s*DW +: DW];
            end
        end
        return e;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(logic [N-1:0] v, logic [N*AW-1:0] d, logic [N*DW-1:0] x);
        exp_t e;
        @(negedge clk);
        e = q.pop_front();
        chk(out_valid == e.v, "R2 out_valid vs model", 64'(out_valid), 64'(e.v));
        chk(src_blocked == e.b, "R5 src_blocked vs model", 64'(src_blocked), 64'(e.b));
        chk(out_data == e.d, "R3 out_data vs model", 64'(out_data), 64'(e.d));
        in_valid = v;
        in_dest  = d;
        in_data  = x;
        q.push_back(model(v, d, x));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step('0, '0, '0);
    endtask

    task automatic shift_wave(int k, output logic [N*AW-1:0] d, output logic [N*DW-1:0] x);
        for (int s = 0; s < N; s++) begin
            d[s*AW +: AW] = AW'((s + k) % N);
            x[s*DW +: DW] = DW'(8'h40 + s + 16 * k);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_MAX) begin
                errors++;
                $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_MAX);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [N*AW-1:0] d, d2;
        logic [N*DW-1:0] x, x2;
        logic [N*DW-1:0] want;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < AW; i++) q.push_back('0);
        // R1
        chk(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(src_blocked == '0, "R1 src_blocked after reset", 64'(src_blocked), 64'd0);
        chk(out_data == '0, "R1 out_data after reset", 64'(out_data), 64'd0);

        // R3 R4: every single pair, back to back
        for (int s = 0; s < N; s++) begin
            for (int t = 0; t < N; t++) begin
                d = '0;
                x = '0;
                d[s*AW +: AW] = AW'(t);
                x[s*DW +: DW] = DW'(s * 16 + t + 1);
                step(N'(1) << s, d, x);
            end
        end
        idle(AW);

        // R7: invalid sources with junk destination and data
        d = '1;
        x = {N{8'hC3}};
        step('0, d, x);
        idle(AW);
        chk(out_valid == '0, "R7 no output from invalid", 64'(out_valid), 64'd0);
        chk(out_data == '0, "R7 zero data when idle", 64'(out_data), 64'd0);
        chk(src_blocked == '0, "R7 no block from invalid", 64'(src_blocked), 64'd0);

        // R5: source 0 and source N/2 share a first-column switch, both pick lower
        d = '0;
        x = '0;
        d[0*AW +: AW]       = AW'(N - 1);
        d[(N/2)*AW +: AW]   = AW'(N - 2);
        x[0*DW +: DW]       = DW'(8'hA5);
        x[(N/2)*DW +: DW]   = DW'(8'h5A);
        step(N'(1) | (N'(1) << (N/2)), d, x);
        idle(AW);
        chk(out_valid == (N'(1) << (N - 1)), "R5 upper wins output", 64'(out_valid), 64'(N'(1) << (N - 1)));
        chk(out_data[(N-1)*DW +: DW] == DW'(8'hA5), "R5 winner data", 64'(out_data[(N-1)*DW +: DW]), 64'hA5);
        chk(src_blocked == (N'(1) << (N/2)), "R5 lower source blocked", 64'(src_blocked), 64'(N'(1) << (N/2)));
        step('0, '0, '0);
        chk(src_blocked == '0, "R5 block lasts one cycle", 64'(src_blocked), 64'd0);
        idle(AW);

        // R8: two shift permutations in consecutive cycles
        shift_wave(1, d, x);
        shift_wave(3, d2, x2);
        step('1, d, x);
        step('1, d2, x2);
        idle(AW - 1);
        for (int s = 0; s < N; s++) want[((s + 1) % N)*DW +: DW] = x[s*DW +: DW];
        chk(out_valid == '1, "R8 shift 1 all delivered", 64'(out_valid), 64'(N'('1)));
        chk(src_blocked == '0, "R8 shift 1 none blocked", 64'(src_blocked), 64'd0);
        chk(out_data == want, "R8 shift 1 data", 64'(out_data), 64'(want));
        step('0, '0, '0);
        for (int s = 0; s < N; s++) want[((s + 3) % N)*DW +: DW] = x2[s*DW +: DW];
        chk(out_valid == '1, "R8 shift 3 next cycle", 64'(out_valid), 64'(N'('1)));
        chk(out_data == want, "R8 shift 3 data", 64'(out_data), 64'(want));
        idle(AW);

        // R2 R5 R6: random waves of varied density
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] v;
            int dens;
            dens = (n / 500) % 4;
            for (int s = 0; s < N; s++) begin
                v[s]          = (($urandom % 4) < dens + 1);
                d[s*AW +: AW] = AW'($urandom);
                x[s*DW +: DW] = DW'($urandom);
            end
            step(v, d, x);
        end
        idle(AW);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule